// File: doc/BRIEF.md
# DRAM Command Timing Sequencer

This block turns single read or write requests into correctly spaced command strobes for one rank of DRAM. Each request carries a bank, a row and a column. The sequencer opens the row, issues the column command, closes the row again, and waits out the recovery time before it accepts more work. Every gap in that sequence comes from a cycle count that software can change at run time, and a read also produces a one-cycle marker at the cycle its data is due. A free-running refresh timer raises a request at a fixed, programmable interval. Refresh always wins over new work: the block finishes the access in flight, closes all banks, issues the refresh, and waits a fixed recovery time.

The sequencer follows a closed-page policy, so only one access is in flight at a time and every access ends with its bank closed. A per-bank open mask records which rows are active. Software loads the five cycle counts through a small write port. A write is accepted only while the idle flag is high and is dropped otherwise.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset, `req_ready` and `cfg_idle` are high, no strobe is active, and the timing counts hold their default parameter values.
- R2: A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `cmd_act` pulses in the next cycle, with `cmd_bank` set to the bank and `cmd_addr` set to the row. `req_ready` stays low from that point until the access completes.
- R3: The column command (`cmd_rd` for a read, `cmd_wr` for a write) comes exactly max(tRCD,1) cycles after `cmd_act`, with the same bank and `cmd_addr` set to the column.
- R4: `cmd_pre` for the same bank comes exactly max(max(tRCD,1)+1, tRAS) cycles after `cmd_act`, so the row is held open for at least tRAS cycles.
- R5: The next `cmd_act` comes at least max(tRP,1)+1 cycles after the previous `cmd_pre`.
- R6: For a read, `rd_valid` pulses for one cycle exactly max(tCL,1) cycles after `cmd_rd`. It never pulses for a write.
- R7: A refresh becomes due every max(tREFI,1) cycles. Once one is due, no new request is accepted. The block issues `cmd_prea`, then `cmd_ref` exactly max(tRP,1) cycles later, and no `cmd_act` follows until more than RFC_CYC cycles after `cmd_ref`.
- R8: A configuration write selects its target with `cfg_sel`: 0 is tCL, 1 is tRCD, 2 is tRP, 3 is tRAS and 4 is tREFI. The four access counts take the low TW bits of `cfg_wdata`. A write takes effect only on an edge where `cfg_idle` is high and is ignored otherwise.
- R9: At most one command strobe is active per cycle. Column commands go only to an open bank, and refresh is issued only when all banks are closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Selects which timing count to write |
| cfg_wdata | input | REFW | Configuration write value |
| cfg_idle | output | 1 | High while the sequencer is idle and accepting configuration |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_bank | input | $clog2(BANKS) | Request bank |
| req_row | input | ROWW | Request row |
| req_col | input | COLW | Request column |
| req_ready | output | 1 | Request can be accepted |
| cmd_act | output | 1 | Row activate strobe |
| cmd_rd | output | 1 | Column read strobe |
| cmd_wr | output | 1 | Column write strobe |
| cmd_pre | output | 1 | Single-bank precharge strobe |
| cmd_prea | output | 1 | All-bank precharge strobe |
| cmd_ref | output | 1 | Refresh strobe |
| cmd_bank | output | $clog2(BANKS) | Bank for the current command |
| cmd_addr | output | max(ROWW,COLW) | Row or column for the current command |
| rd_valid | output | 1 | Read data due this cycle |

## Verification
The assertions assume that the request fields stay stable while `req_valid` is high. They also assume that configuration writes arrive one cycle at a time. The stimulus keeps to both rules: it raises a request only when `req_ready` is high and drops it one cycle after acceptance. The timing counts must also fit in TW bits, and the recovery count must stay below the counter's saturation value. The bench stays within both limits, and it changes timing counts only between accesses, except in the one deliberate busy-time write that checks R8.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RCD,
    ST_RAS,
    ST_RP,
    ST_RPA,
    ST_RFC
  } seq_st_e;

  localparam logic [2:0] CSEL_TCL  = 3'd0;
  localparam logic [2:0] CSEL_TRCD = 3'd1;
  localparam logic [2:0] CSEL_TRP  = 3'd2;
  localparam logic [2:0] CSEL_TRAS = 3'd3;
  localparam logic [2:0] CSEL_REFI = 3'd4;
  localparam int         NUM_TIM   = 4;
endpackage

// File: rtl/dseq_cfg.sv
module dseq_cfg #(
  parameter int TW        = 6,
  parameter int REFW      = 12,
  parameter int DEF_TCL   = 4,
  parameter int DEF_TRCD  = 3,
  parameter int DEF_TRP   = 3,
  parameter int DEF_TRAS  = 8,
  parameter int DEF_TREFI = 1000
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 we,
  input  logic [2:0]                           sel,
  input  logic [REFW-1:0]                      wdata,
  input  logic                                 allow,
  output logic [dseq_pkg::NUM_TIM-1:0][TW-1:0] tims,
  output logic [REFW-1:0]                      t_refi
);
  import dseq_pkg::*;

  for (genvar i = 0; i < NUM_TIM; i++) begin : g_tim
    localparam int DV = (i == 0) ? DEF_TCL : (i == 1) ? DEF_TRCD :
                        (i == 2) ? DEF_TRP : DEF_TRAS;
    logic [TW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= TW'(DV);
      else if (we && allow && sel == 3'(i)) q <= wdata[TW-1:0];
    end
    assign tims[i] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) t_refi <= REFW'(DEF_TREFI);
    else if (we && allow && sel == CSEL_REFI) t_refi <= wdata;
  end
endmodule

// File: rtl/dseq_refresh.sv
module dseq_refresh #(
  parameter int REFW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [REFW-1:0] t_refi,
  input  logic            ack,
  output logic            pend
);
  logic [REFW-1:0] rcnt;
  logic            expire;

  assign expire = ({1'b0, rcnt} + 1'b1) >= {1'b0, t_refi};

  always_ff @(posedge clk) begin
    if (rst) begin
      rcnt <= '0;
      pend <= 1'b0;
    end else begin
      if (expire) begin
        rcnt <= '0;
        pend <= 1'b1;
      end else begin
        rcnt <= rcnt + 1'b1;
        if (ack) pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dseq_fsm.sv
module dseq_fsm #(
  parameter int TW      = 6,
  parameter int BANKS   = 4,
  parameter int ROWW    = 12,
  parameter int COLW    = 10,
  parameter int RFC_CYC = 8,
  localparam int BW     = $clog2(BANKS),
  localparam int AW     = (ROWW > COLW) ? ROWW : COLW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TW-1:0]    t_cl,
  input  logic [TW-1:0]    t_rcd,
  input  logic [TW-1:0]    t_rp,
  input  logic [TW-1:0]    t_ras,
  input  logic             ref_pend,
  output logic             ref_ack,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [BW-1:0]    req_bank,
  input  logic [ROWW-1:0]  req_row,
  input  logic [COLW-1:0]  req_col,
  output logic             req_ready,
  output logic             idle,
  output logic             cmd_act,
  output logic             cmd_rd,
  output logic             cmd_wr,
  output logic             cmd_pre,
  output logic             cmd_prea,
  output logic             cmd_ref,
  output logic [BW-1:0]    cmd_bank,
  output logic [AW-1:0]    cmd_addr,
  output logic             rd_valid,
  output logic [BANKS-1:0] open_q
);
  import dseq_pkg::*;

  seq_st_e         st;
  logic [TW-1:0]   cnt, ras_cnt, rdc;
  logic            rd_busy;
  logic            w_q;
  logic [BW-1:0]   bank_q;
  logic [COLW-1:0] col_q;

  function automatic logic [TW-1:0] sat_inc(input logic [TW-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  assign idle      = (st == ST_IDLE);
  assign req_ready = idle && !ref_pend;
  assign ref_ack   = (st == ST_RPA) && (cnt >= t_rp);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      ras_cnt  <= '0;
      rdc      <= '0;
      rd_busy  <= 1'b0;
      rd_valid <= 1'b0;
      cmd_act  <= 1'b0;
      cmd_rd   <= 1'b0;
      cmd_wr   <= 1'b0;
      cmd_pre  <= 1'b0;
      cmd_prea <= 1'b0;
      cmd_ref  <= 1'b0;
      cmd_bank <= '0;
      cmd_addr <= '0;
      open_q   <= '0;
      w_q      <= 1'b0;
      bank_q   <= '0;
      col_q    <= '0;
    end else begin
      cmd_act  <= 1'b0;
      cmd_rd   <= 1'b0;
      cmd_wr   <= 1'b0;
      cmd_pre  <= 1'b0;
      cmd_prea <= 1'b0;
      cmd_ref  <= 1'b0;
      rd_valid <= 1'b0;
      cnt      <= sat_inc(cnt);
      ras_cnt  <= sat_inc(ras_cnt);
      if (rd_busy) begin
        if (rdc >= t_cl) begin
          rd_valid <= 1'b1;
          rd_busy  <= 1'b0;
        end else begin
          rdc <= rdc + 1'b1;
        end
      end
      case (st)
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_prea <= 1'b1;
            open_q   <= '0;
            cnt      <= TW'(1);
            st       <= ST_RPA;
          end else if (req_valid) begin
            cmd_act          <= 1'b1;
            cmd_bank         <= req_bank;
            cmd_addr         <= AW'(req_row);
            open_q[req_bank] <= 1'b1;
            w_q              <= req_write;
            bank_q           <= req_bank;
            col_q            <= req_col;
            cnt              <= TW'(1);
            ras_cnt          <= TW'(1);
            st               <= ST_RCD;
          end
        end
        ST_RCD: begin
          if (cnt >= t_rcd) begin
            cmd_rd   <= !w_q;
            cmd_wr   <= w_q;
            cmd_bank <= bank_q;
            cmd_addr <= AW'(col_q);
            if (!w_q) begin
              rd_busy <= 1'b1;
              rdc     <= TW'(1);
            end
            st <= ST_RAS;
          end
        end
        ST_RAS: begin
          if (ras_cnt >= t_ras) begin
            cmd_pre        <= 1'b1;
            cmd_bank       <= bank_q;
            open_q[bank_q] <= 1'b0;
            cnt            <= TW'(1);
            st             <= ST_RP;
          end
        end
        ST_RP: begin
          if (cnt >= t_rp && !rd_busy) st <= ST_IDLE;
        end
        ST_RPA: begin
          if (cnt >= t_rp) begin
            cmd_ref <= 1'b1;
            cnt     <= TW'(1);
            st      <= ST_RFC;
          end
        end
        ST_RFC: begin
          if (cnt >= TW'(RFC_CYC)) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq #(
  parameter int TW        = 6,
  parameter int REFW      = 12,
  parameter int BANKS     = 4,
  parameter int ROWW      = 12,
  parameter int COLW      = 10,
  parameter int RFC_CYC   = 8,
  parameter int DEF_TCL   = 4,
  parameter int DEF_TRCD  = 3,
  parameter int DEF_TRP   = 3,
  parameter int DEF_TRAS  = 8,
  parameter int DEF_TREFI = 1000,
  localparam int BW       = $clog2(BANKS),
  localparam int AW       = (ROWW > COLW) ? ROWW : COLW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_sel,
  input  logic [REFW-1:0] cfg_wdata,
  output logic            cfg_idle,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [BW-1:0]   req_bank,
  input  logic [ROWW-1:0] req_row,
  input  logic [COLW-1:0] req_col,
  output logic            req_ready,
  output logic            cmd_act,
  output logic            cmd_rd,
  output logic            cmd_wr,
  output logic            cmd_pre,
  output logic            cmd_prea,
  output logic            cmd_ref,
  output logic [BW-1:0]   cmd_bank,
  output logic [AW-1:0]   cmd_addr,
  output logic            rd_valid
);
  import dseq_pkg::*;

  logic [NUM_TIM-1:0][TW-1:0] tims;
  logic [TW-1:0]              t_cl, t_rcd, t_rp, t_ras;
  logic [REFW-1:0]            t_refi;
  logic                       ref_pend, ref_ack;
  logic [BANKS-1:0]           bank_open;

  assign t_cl  = tims[0];
  assign t_rcd = tims[1];
  assign t_rp  = tims[2];
  assign t_ras = tims[3];

  dseq_cfg #(
    .TW(TW), .REFW(REFW), .DEF_TCL(DEF_TCL), .DEF_TRCD(DEF_TRCD),
    .DEF_TRP(DEF_TRP), .DEF_TRAS(DEF_TRAS), .DEF_TREFI(DEF_TREFI)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .allow(cfg_idle), .tims(tims), .t_refi(t_refi)
  );

  dseq_refresh #(.REFW(REFW)) u_ref (
    .clk(clk), .rst(rst), .t_refi(t_refi), .ack(ref_ack), .pend(ref_pend)
  );

  dseq_fsm #(
    .TW(TW), .BANKS(BANKS), .ROWW(ROWW), .COLW(COLW), .RFC_CYC(RFC_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .t_cl(t_cl), .t_rcd(t_rcd), .t_rp(t_rp),
    .t_ras(t_ras), .ref_pend(ref_pend), .ref_ack(ref_ack),
    .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_ready(req_ready),
    .idle(cfg_idle), .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_pre(cmd_pre), .cmd_prea(cmd_prea), .cmd_ref(cmd_ref),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .rd_valid(rd_valid),
    .open_q(bank_open)
  );
endmodule

// File: rtl/dseq_chk.sv
module dseq_chk #(
  parameter int TW    = 6,
  parameter int REFW  = 12,
  parameter int BANKS = 4,
  localparam int BW   = $clog2(BANKS)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             cfg_idle,
  input logic             cmd_act,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic             cmd_pre,
  input logic             cmd_prea,
  input logic             cmd_ref,
  input logic [BW-1:0]    cmd_bank,
  input logic             rd_valid,
  input logic [BANKS-1:0] bank_open,
  input logic [TW-1:0]    t_cl,
  input logic [TW-1:0]    t_rcd,
  input logic [TW-1:0]    t_rp,
  input logic [TW-1:0]    t_ras,
  input logic [REFW-1:0]  t_refi
);
  a_r9_one_cmd: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_prea, cmd_ref}));

  a_r9_col_open: assert property (@(posedge clk) disable iff (rst)
    (cmd_rd || cmd_wr) |-> bank_open[cmd_bank]);

  a_r7_ref_closed: assert property (@(posedge clk) disable iff (rst)
    cmd_ref |-> (bank_open == '0));

  a_r2_act_handshake: assert property (@(posedge clk) disable iff (rst)
    cmd_act |-> $past(req_valid && req_ready));

  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_idle |=> $stable({t_cl, t_rcd, t_rp, t_ras, t_refi}));

  a_r6_rdv_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

bind dram_cmd_seq dseq_chk #(.TW(TW), .REFW(REFW), .BANKS(BANKS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cfg_idle(cfg_idle), .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
  .cmd_pre(cmd_pre), .cmd_prea(cmd_prea), .cmd_ref(cmd_ref),
  .cmd_bank(cmd_bank), .rd_valid(rd_valid), .bank_open(bank_open),
  .t_cl(t_cl), .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras), .t_refi(t_refi)
);

// File: tb/sim_dram_cmd_seq.sv
`timescale 1ns/1ps
module sim_dram_cmd_seq;
  localparam int TW = 6, REFW = 12, BANKS = 4, ROWW = 12, COLW = 10, RFC = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [REFW-1:0] cfg_wdata = '0;
  logic cfg_idle, req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [1:0] req_bank = '0;
  logic [ROWW-1:0] req_row = '0;
  logic [COLW-1:0] req_col = '0;
  logic cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_prea, cmd_ref, rd_valid;
  logic [1:0] cmd_bank;
  logic [11:0] cmd_addr;

  always #4 clk = ~clk;

  dram_cmd_seq #(.TW(TW), .REFW(REFW), .BANKS(BANKS), .ROWW(ROWW),
                 .COLW(COLW), .RFC_CYC(RFC)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_idle(cfg_idle), .req_valid(req_valid),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_ready(req_ready), .cmd_act(cmd_act),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre), .cmd_prea(cmd_prea),
    .cmd_ref(cmd_ref), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .rd_valid(rd_valid)
  );

  int errors = 0, checks = 0, cyc = 0;
  int m_cl = 4, m_rcd = 3, m_rp = 3, m_ras = 8;
  int t_act = -1, t_col = -1, t_pre = -1, t_prea = -1, t_ref = -1, rd_due = -1;
  int exp_bank = 0, exp_row = 0, exp_col = 0, ref_cnt = 0;
  bit exp_w = 0, win = 0, done = 0;

  function automatic int mx1(int v); return (v < 1) ? 1 : v; endfunction
  function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      chk($countones({cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_prea, cmd_ref}) <= 1,
          "R9 one strobe", $countones({cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_prea, cmd_ref}), 1);
      if (rd_due >= 0 && cyc > rd_due) begin
        chk(0, "R6 rd_valid missing", cyc, rd_due);
        rd_due = -1;
      end
      if (cmd_act) begin
        chk(cmd_bank == exp_bank && cmd_addr == exp_row, "R2 act bank/row",
            {cmd_bank, cmd_addr}, {exp_bank[1:0], exp_row[11:0]});
        if (t_pre >= 0) chk(cyc - t_pre >= mx1(m_rp) + 1, "R5 pre->act", cyc - t_pre, mx1(m_rp) + 1);
        if (t_ref >= 0) chk(cyc - t_ref > RFC, "R7 ref recovery", cyc - t_ref, RFC + 1);
        chk(!(t_prea > t_ref), "R7 act inside refresh", t_prea, t_ref);
        t_act = cyc;
      end
      if (cmd_rd || cmd_wr) begin
        chk(cmd_wr == exp_w, "R3 column kind", cmd_wr, exp_w);
        chk(cmd_bank == exp_bank && cmd_addr == exp_col, "R3 column bank/col",
            {cmd_bank, cmd_addr}, {exp_bank[1:0], exp_col[11:0]});
        chk(cyc - t_act == mx1(m_rcd), "R3 act->col", cyc - t_act, mx1(m_rcd));
        t_col = cyc;
        if (cmd_rd) rd_due = cyc + mx1(m_cl);
      end
      if (rd_valid) begin
        chk(rd_due == cyc, "R6 rd_valid time", cyc, rd_due);
        rd_due = -1;
      end
      if (cmd_pre) begin
        chk(cyc - t_act == mx(mx1(m_rcd) + 1, m_ras), "R4 act->pre",
            cyc - t_act, mx(mx1(m_rcd) + 1, m_ras));
        chk(cmd_bank == exp_bank, "R4 pre bank", cmd_bank, exp_bank);
        t_pre = cyc;
      end
      if (cmd_prea) t_prea = cyc;
      if (cmd_ref) begin
        chk(cyc - t_prea == mx1(m_rp), "R7 prea->ref", cyc - t_prea, mx1(m_rp));
        t_ref = cyc;
        if (win) ref_cnt++;
      end
    end
  end

  task automatic cfg_write(int sel, int val);
    @(negedge clk);
    while (!cfg_idle) @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = REFW'(val);
    case (sel)
      0: m_cl = val;
      1: m_rcd = val;
      2: m_rp = val;
      3: m_ras = val;
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_req(bit w, int b, int r, int c);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_w = w; exp_bank = b; exp_row = r; exp_col = c;
    req_valid = 1; req_write = w; req_bank = 2'(b);
    req_row = ROWW'(r); req_col = COLW'(c);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready && cfg_idle, "R1 ready/idle after reset", {req_ready, cfg_idle}, 3);
    chk({cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_prea, cmd_ref, rd_valid} == 0,
        "R1 strobes quiet", {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_prea, cmd_ref}, 0);
    // R1: first accesses run on the default timing counts (modelled as 4/3/3/8)
    do_req(0, 2, 100, 17);
    do_req(1, 3, 55, 9);
    wait_idle();
    // R3 R4 R5 R6: sweep of access timing counts
    for (int a = 0; a < 3; a++)
      for (int s = 0; s < 3; s++)
        for (int l = 0; l < 3; l++)
          for (int p = 0; p < 2; p++) begin
            cfg_write(1, (a == 0) ? 0 : (a == 1) ? 2 : 5);
            cfg_write(3, (s == 0) ? 2 : (s == 1) ? 6 : 11);
            cfg_write(0, (l == 0) ? 0 : (l == 1) ? 2 : 5);
            cfg_write(2, (p == 0) ? 1 : 4);
            do_req(0, (a + s) % 4, a * 97 + s * 13 + l, l * 31 + p);
            do_req(1, (l + p) % 4, 4095 - a - p, 1023 - s);
            do_req(0, p, s * 7, a);
            wait_idle();
          end
    // R8: write during busy is ignored
    cfg_write(1, 3);
    cfg_write(3, 4);
    fork
      do_req(0, 1, 5, 9);
      begin
        @(negedge clk);
        while (cfg_idle) @(negedge clk);
        chk(!cfg_idle, "R8 idle low while busy", cfg_idle, 0);
        cfg_we = 1; cfg_sel = 3'd1; cfg_wdata = REFW'(7);
        @(negedge clk);
        cfg_we = 0;
      end
    join
    wait_idle();
    do_req(1, 2, 6, 3);
    wait_idle();
    chk(t_col - t_act == 3, "R8 ignored write kept tRCD", t_col - t_act, 3);
    // R7: refresh interval under a saturating request stream
    cfg_write(4, 60);
    cfg_write(2, 2);
    repeat (70) @(negedge clk);
    begin
      int start;
      start = cyc;
      win = 1;
      while (cyc < start + 600) do_req((cyc % 2) == 1, cyc % 4, cyc % 4096, cyc % 1024);
      win = 0;
      chk(ref_cnt >= 9 && ref_cnt <= 11, "R7 refresh count", ref_cnt, 10);
    end
    wait_idle();
    repeat (20) @(negedge clk);
    done = 1;
    report();
  end
endmodule